// File: doc/BRIEF.md
# Instruction Cycle Timing Sequencer

This block is the front end of a 16-bit accumulator machine. A small sequence counter is decoded into one-hot phase lines. On those phases the block fetches an instruction word from a synchronous word memory and decodes its opcode field into one-hot opcode lines. For an indirect memory-reference word, it also fetches the effective address. It holds the program counter, the address register, the instruction register and the indirect flag.

Execution units outside the block watch the phase lines, the opcode lines and three class strobes: register class, I/O class and memory class. When an execution unit has finished, it raises a clear request, and the next instruction starts again at phase 0. A run flag gates all activity. Reset leaves the machine stopped. A start pulse sets the run flag and a halt pulse clears it.

Top module: `icseq_top`

## Requirements
- R1: After reset, phase line 0 is the only active phase line (`phase_t` = 0x0001). `pc`, `ar`, `ir`, `opc_d` and `ind_flag` are all zero, and `running`, `mem_rd` and all three class strobes are low.
- R2: While the run flag is low and no clear request is present, the phase lines hold their value, no register changes and `mem_rd` stays low.
- R3: While running with no clear request, the counter advances by one phase per clock with exactly one phase line active, and it wraps from phase 15 back to phase 0.
- R4: A clear request (`sc_clr` high at a clock edge) makes phase 0 active after that edge. It takes priority over advancing and also acts while stopped.
- R5: On a running phase-0 cycle, `ar` takes the value of `pc`, and no memory read is issued.
- R6: On a running phase-1 cycle, `mem_rd` is high and `mem_addr` equals `ar`. At the end of that cycle, `ir` takes `mem_rdata` and `pc` increments by one, modulo 2^12.
- R7: On a running phase-2 cycle, the opcode lines take a one-hot decode of `ir[14:12]` (bit n set for value n). In the same cycle, `ar` takes `ir[11:0]` and `ind_flag` takes `ir[15]`.
- R8: On a running phase-3 cycle with `opc_d[7]` low and `ind_flag` high, `mem_rd` is high with `mem_addr` = `ar`, and `ar` takes `mem_rdata[11:0]`.
- R9: On a running phase-3 cycle with `opc_d[7]` low and `ind_flag` low, `ar` is unchanged and `mem_rd` is low.
- R10: `rr_stb` is high exactly on running phase-3 cycles with `opc_d[7]` high and `ind_flag` low. `io_stb` is high exactly on running phase-3 cycles with `opc_d[7]` high and `ind_flag` high.
- R11: `mr_stb` is high exactly on running phase-4 cycles with `opc_d[7]` low. At most one class strobe is ever high.
- R12: `run_set` sets the run flag and `run_clr` clears it. When both are high, clearing wins. The flag drives `running`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_set | input | 1 | Start pulse, sets run flag |
| run_clr | input | 1 | Halt pulse, clears run flag |
| sc_clr | input | 1 | Clear request from execution units |
| mem_rdata | input | 16 | Memory read data, valid in the read cycle |
| mem_addr | output | 12 | Memory address (address register) |
| mem_rd | output | 1 | Memory read request |
| phase_t | output | 16 | One-hot phase lines |
| opc_d | output | 8 | One-hot opcode decode |
| ind_flag | output | 1 | Indirect bit of current instruction |
| pc | output | 12 | Program counter |
| ar | output | 12 | Address register |
| ir | output | 16 | Instruction register |
| rr_stb | output | 1 | Register-class execute strobe |
| io_stb | output | 1 | I/O-class execute strobe |
| mr_stb | output | 1 | Memory-class execute strobe |
| running | output | 1 | Run flag |

## Verification
The hardest situations to reach from the ports are the indirect address fetch and the counter wrap past phase 15. The indirect fetch needs a word whose top bit is set and whose opcode is below 7, plus a pointer word placed at the operand address. The wrap needs the execution side to withhold its clear request for more than sixteen cycles. The stimulus loads a small program into the bench memory model and plays the execution units. It raises the clear request at phase 3 or phase 5, depending on the class, and omits it once for eighteen cycles. Every cycle's outputs are checked against a reference model built from the requirements.

// File: rtl/icseq_pkg.sv
package icseq_pkg;
  // fixed phase slots used by the fetch/decode sequence
  localparam int unsigned PH_ADDR   = 0;
  localparam int unsigned PH_FETCH  = 1;
  localparam int unsigned PH_DECODE = 2;
  localparam int unsigned PH_BRANCH = 3;
  localparam int unsigned PH_MEXEC  = 4;

  typedef struct packed {
    logic rr;
    logic io;
    logic mr;
  } cls_stb_t;
endpackage

// File: rtl/icseq_phase_ctr.sv
module icseq_phase_ctr #(
  parameter int unsigned CNT_W = 4,
  localparam int unsigned NPH = 1 << CNT_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           adv,
  input  logic           clr,
  output logic [NPH-1:0] t
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (adv)   cnt_q <= cnt_q + CNT_W'(1);
  end

  for (genvar g = 0; g < NPH; g++) begin : g_dec
    assign t[g] = (cnt_q == CNT_W'(g));
  end

  a_r4_clear_to_zero: assert property (@(posedge clk) disable iff (rst)
    clr |=> t[0]);
  a_r3_advance: assert property (@(posedge clk) disable iff (rst)
    (adv && !clr) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (!adv && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/icseq_opdec.sv
module icseq_opdec #(
  parameter int unsigned OPC_W = 3,
  localparam int unsigned NOP = 1 << OPC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [OPC_W-1:0] sel,
  output logic [NOP-1:0]   d_q
);
  logic [NOP-1:0] dec;

  for (genvar g = 0; g < NOP; g++) begin : g_line
    assign dec[g] = (sel == OPC_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst)       d_q <= '0;
    else if (load) d_q <= dec;
  end

  a_r7_at_most_one: assert property (@(posedge clk) disable iff (rst)
    $onehot0(d_q));
  a_r7_loaded_onehot: assert property (@(posedge clk) disable iff (rst)
    load |=> $onehot(d_q));
endmodule

// File: rtl/icseq_top.sv
module icseq_top #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned SC_W   = 4,
  parameter int unsigned OPC_W  = 3,
  localparam int unsigned NPH   = 1 << SC_W,
  localparam int unsigned NOP   = 1 << OPC_W,
  localparam int unsigned IND_B = WORD_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_set,
  input  logic              run_clr,
  input  logic              sc_clr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic [NPH-1:0]    phase_t,
  output logic [NOP-1:0]    opc_d,
  output logic              ind_flag,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] ar,
  output logic [WORD_W-1:0] ir,
  output logic              rr_stb,
  output logic              io_stb,
  output logic              mr_stb,
  output logic              running
);
  import icseq_pkg::*;

  logic              run_q;
  logic [ADDR_W-1:0] pc_q, ar_q;
  logic [WORD_W-1:0] ir_q;
  logic              ind_q;
  logic [NPH-1:0]    t;
  logic [NOP-1:0]    d;
  logic              is_mref, do_ind;
  cls_stb_t          stb;

  // run flag: halt wins over start
  always_ff @(posedge clk) begin
    if (rst || run_clr) run_q <= 1'b0;
    else if (run_set)   run_q <= 1'b1;
  end

  icseq_phase_ctr #(.CNT_W(SC_W)) u_ctr (
    .clk(clk), .rst(rst), .adv(run_q), .clr(sc_clr), .t(t)
  );

  icseq_opdec #(.OPC_W(OPC_W)) u_dec (
    .clk(clk), .rst(rst),
    .load(run_q && t[PH_DECODE]),
    .sel(ir_q[IND_B-1 -: OPC_W]),
    .d_q(d)
  );

  assign is_mref = !d[NOP-1];
  assign do_ind  = run_q && t[PH_BRANCH] && is_mref && ind_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      ar_q  <= '0;
      ir_q  <= '0;
      ind_q <= 1'b0;
    end else if (run_q) begin
      if (t[PH_ADDR]) ar_q <= pc_q;
      if (t[PH_FETCH]) begin
        ir_q <= mem_rdata;
        pc_q <= pc_q + ADDR_W'(1);
      end
      if (t[PH_DECODE]) begin
        ar_q  <= ir_q[ADDR_W-1:0];
        ind_q <= ir_q[IND_B];
      end
      if (do_ind) ar_q <= mem_rdata[ADDR_W-1:0];
    end
  end

  assign stb.rr = run_q && t[PH_BRANCH] && !is_mref && !ind_q;
  assign stb.io = run_q && t[PH_BRANCH] && !is_mref &&  ind_q;
  assign stb.mr = run_q && t[PH_MEXEC]  &&  is_mref;

  assign mem_addr = ar_q;
  assign mem_rd   = (run_q && t[PH_FETCH]) || do_ind;
  assign phase_t  = t;
  assign opc_d    = d;
  assign ind_flag = ind_q;
  assign pc       = pc_q;
  assign ar       = ar_q;
  assign ir       = ir_q;
  assign rr_stb   = stb.rr;
  assign io_stb   = stb.io;
  assign mr_stb   = stb.mr;
  assign running  = run_q;

  a_r2_no_read_stopped: assert property (@(posedge clk) disable iff (rst)
    !running |-> !mem_rd);
  a_r5_ar_from_pc: assert property (@(posedge clk) disable iff (rst)
    (running && phase_t[0]) |=> (ar == $past(pc)));
  a_r6_pc_step: assert property (@(posedge clk) disable iff (rst)
    (running && phase_t[1]) |=> (pc == $past(pc) + ADDR_W'(1)));
  a_r8_ind_load: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && phase_t[3]) |=> (ar == $past(mem_rdata[ADDR_W-1:0])));
  a_r11_one_class: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rr_stb, io_stb, mr_stb}));
  a_r12_halt_wins: assert property (@(posedge clk) disable iff (rst)
    run_clr |=> !running);
endmodule

// File: tb/icseq_top_bench.sv
module icseq_top_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run_set = 1'b0, run_clr = 1'b0, sc_clr = 1'b0;
  logic [15:0] mem_rdata;
  logic [11:0] mem_addr, pc, ar;
  logic        mem_rd, ind_flag, rr_stb, io_stb, mr_stb, running;
  logic [15:0] phase_t, ir;
  logic [7:0]  opc_d;

  logic [15:0] mem [0:255];
  assign mem_rdata = mem[mem_addr[7:0]];

  always #(CLK_PERIOD/2) clk = ~clk;

  icseq_top u_icseq_top (
    .clk(clk), .rst(rst), .run_set(run_set), .run_clr(run_clr), .sc_clr(sc_clr),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .phase_t(phase_t), .opc_d(opc_d), .ind_flag(ind_flag), .pc(pc), .ar(ar),
    .ir(ir), .rr_stb(rr_stb), .io_stb(io_stb), .mr_stb(mr_stb), .running(running)
  );

  int checks = 0;
  int errors = 0;

  // reference model state
  int          m_sc = 0;
  logic        m_run = 1'b0;
  logic [11:0] m_pc = '0, m_ar = '0;
  logic [15:0] m_ir = '0;
  logic        m_i = 1'b0;
  logic [7:0]  m_d = '0;

  logic [81:0] exp_q [$];
  string       tag_q [$];

  function automatic logic [81:0] actual_vec();
    return {phase_t, pc, ar, mem_addr, ir, opc_d, ind_flag, mem_rd,
            rr_stb, io_stb, mr_stb, running};
  endfunction

  function automatic logic [81:0] model_vec();
    logic rd, rr, io, mr;
    rd = m_run && (m_sc == 1 || (m_sc == 3 && !m_d[7] && m_i));
    rr = m_run && m_sc == 3 && m_d[7] && !m_i;
    io = m_run && m_sc == 3 && m_d[7] && m_i;
    mr = m_run && m_sc == 4 && !m_d[7];
    return {16'(1) << m_sc, m_pc, m_ar, m_ar, m_ir, m_d, m_i, rd, rr, io, mr, m_run};
  endfunction

  task automatic chk(input string tag, input logic [81:0] act, input logic [81:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: drive one cycle of inputs and push the expected post-edge state
  task automatic step(input string tag, input logic clr, input logic set, input logic stp);
    logic [15:0] rdw;
    @(negedge clk);
    sc_clr = clr; run_set = set; run_clr = stp;
    if (m_run) begin
      case (m_sc)
        0: m_ar = m_pc;
        1: begin m_ir = mem[m_ar[7:0]]; m_pc = m_pc + 12'd1; end
        2: begin m_d = 8'(1) << m_ir[14:12]; m_ar = m_ir[11:0]; m_i = m_ir[15]; end
        3: if (!m_d[7] && m_i) begin rdw = mem[m_ar[7:0]]; m_ar = rdw[11:0]; end
        default: ;
      endcase
    end
    if (clr) m_sc = 0;
    else if (m_run) m_sc = (m_sc + 1) % 16;
    if (stp) m_run = 1'b0;
    else if (set) m_run = 1'b1;
    exp_q.push_back(model_vec());
    tag_q.push_back(tag);
  endtask

  task automatic exec_instr(input string tag);
    step({tag, " ph0"}, 1'b0, 1'b0, 1'b0);
    step({tag, " ph1"}, 1'b0, 1'b0, 1'b0);
    step({tag, " ph2"}, 1'b0, 1'b0, 1'b0);
    if (m_d[7]) begin
      step({tag, " ph3 clr"}, 1'b1, 1'b0, 1'b0);
    end else begin
      step({tag, " ph3"}, 1'b0, 1'b0, 1'b0);
      step({tag, " ph4"}, 1'b0, 1'b0, 1'b0);
      step({tag, " ph5 clr"}, 1'b1, 1'b0, 1'b0);
    end
  endtask

  // monitor: compare a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (exp_q.size() > 0) chk(tag_q.pop_front(), actual_vec(), exp_q.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 256; k++) mem[k] = 16'h0000;
    mem[0]     = 16'h7800;   // register class
    mem[1]     = 16'hF800;   // I/O class
    mem[2]     = 16'h2010;   // direct memory class
    mem[3]     = 16'hA020;   // indirect memory class
    mem[8'h20] = 16'h0055;   // pointer word
    mem[4]     = 16'h1030;   // direct, used for the wrap run
    mem[5]     = 16'h7001;
    mem[8'h30] = 16'h0000;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 reset state", actual_vec(), model_vec());

    step("R2 idle stopped", 1'b0, 1'b0, 1'b0);
    step("R2 idle stopped", 1'b0, 1'b0, 1'b0);
    step("R4 clear while stopped", 1'b1, 1'b0, 1'b0);
    step("R12 start", 1'b0, 1'b1, 1'b0);

    exec_instr("R10 R5 R6 R7 register class");
    exec_instr("R10 io class");
    exec_instr("R9 R11 direct memory class");
    exec_instr("R8 R11 indirect memory class");

    // R3: no clear request for 18 cycles -> wrap past phase 15
    for (int k = 0; k < 18; k++) step("R3 free run and wrap", 1'b0, 1'b0, 1'b0);
    step("R4 clear mid run", 1'b1, 1'b0, 1'b0);
    step("R3 advance", 1'b0, 1'b0, 1'b0);
    step("R3 advance", 1'b0, 1'b0, 1'b0);
    step("R12 halt wins over start", 1'b0, 1'b1, 1'b1);
    step("R2 hold after halt", 1'b0, 1'b0, 1'b0);
    step("R2 hold after halt", 1'b0, 1'b0, 1'b0);
    step("R4 clear while halted", 1'b1, 1'b0, 1'b0);
    step("R2 hold after clear", 1'b0, 1'b0, 1'b0);

    while (exp_q.size() > 0) @(posedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule